// File: doc/BRIEF.md
# Twin-Predicated Element Index Sequencer

This block steps through the elements of one vector operation that is built by looping a scalar operation, and each clock it produces at most one pair of element indices: one for the source array and one for the destination array. Each side has its own predicate mask, where bit i belongs to element i, and its own mode for masked-off elements. In skip mode a masked-off element is passed over and consumes no operation. In zero mode it still takes part: a masked-off source element is read as zero, and a masked-off destination element receives a zero.

The two sides are predicated independently, so the source and destination indices can drift apart. Skipping on the source side alone compresses the source elements into a dense destination run. Skipping on the destination side alone expands a dense source run into the set destination slots. Skipping on both sides does both at once. A downstream datapath uses `src_idx`, `dst_idx` and the two zero flags whenever `dst_wr_en` is high, and it treats `done` as the end of the operation.

The controller has two states. `ST_IDLE` waits for `start`. On `start` the block captures the length, the masks and the modes, resets both cursors, and takes the `IDLE->RUN` transition. `ST_RUN` makes one decision per cycle: finish, skip, or issue. When either cursor reaches the vector length it pulses `done` and takes the `RUN->IDLE` transition. `start` has no effect in `ST_RUN`.

Top module: `twin_pred_seq`

## Requirements
- R1: After reset, and whenever no operation is running, `dst_wr_en`, `dst_wr_zero`, `src_is_zero` and `done` are all 0.
- R2: On `start` in idle, the block captures `vec_len`, both masks and both mode bits. The first decision appears in the cycle after the capture edge. A `start` pulse or an input change while an operation runs has no effect on that operation.
- R3: In source skip mode (`src_zero_mode`=0), a source element whose mask bit is 0 advances the source index by one in a cycle that issues no pair.
- R4: In source zero mode (`src_zero_mode`=1), a source element whose mask bit is 0 is issued in a pair with `src_is_zero`=1.
- R5: In destination skip mode (`dst_zero_mode`=0), a destination element whose mask bit is 0 advances the destination index by one in a cycle with `dst_wr_en`=0, and so that element is left unwritten.
- R6: In destination zero mode (`dst_zero_mode`=1), a destination element whose mask bit is 0 is issued with `dst_wr_en`=1 and `dst_wr_zero`=1.
- R7: At most one pair is issued per cycle, and an issued pair advances both indices by exactly one. If both sides skip in the same cycle, both indices advance together.
- R8: As soon as either index equals the captured length, `done` is high for exactly one cycle, no pair is issued in that cycle, and the block returns to idle.
- R9: A vector length of 0 gives `done` in the first cycle after the capture edge, with no pairs issued.
- R10: Mask bit i belongs to element i. Lengths from 0 to 64 are supported, and a length above 64 is treated as 64. Every issued index is below 64.
- R11: With skip mode on both sides, the issued pairs are the set source bits taken in order, matched with the set destination bits taken in order. With equal masks but different modes, the two indices fall out of step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (sampled in idle) |
| vec_len | input | 7 | Number of elements, 0..64 |
| src_mask | input | 64 | Source predicate, bit i for element i |
| dst_mask | input | 64 | Destination predicate, bit i for element i |
| src_zero_mode | input | 1 | 1: masked source reads zero; 0: skip |
| dst_zero_mode | input | 1 | 1: masked destination gets zero; 0: skip |
| src_idx | output | 7 | Current source element index |
| dst_idx | output | 7 | Current destination element index |
| src_is_zero | output | 1 | Issued source operand is to be taken as zero |
| dst_wr_en | output | 1 | A pair is issued this cycle |
| dst_wr_zero | output | 1 | The issued destination receives zero |
| done | output | 1 | One-cycle end-of-operation pulse |

## Verification
All outputs come from registers through combinational decode, so the first decision is visible in the first cycle after the edge that samples `start`. Each later cycle shows exactly one more decision. The bench models the operation from the requirements and records, for each operation, the ordered list of issued pairs and the number of cycles up to and including the one with `done`. A monitor samples on the falling edge. It counts cycles from the capture edge, pops one expected pair for each cycle with `dst_wr_en` high, and at `done` checks both the cycle count and that the list is empty.

// File: rtl/twin_pred_pkg.sv
package twin_pred_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_t;

    typedef enum logic [0:0] {
        PM_SKIP = 1'b0,
        PM_ZERO = 1'b1
    } pred_mode_t;

endpackage

// File: rtl/pred_cursor.sv
module pred_cursor #(
    parameter int MAX_VL = 64,
    parameter int IDX_W  = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [MAX_VL-1:0] mask_in,
    input  logic [IDX_W-1:0]  vl_in,
    output logic [IDX_W-1:0]  idx,
    output logic              bit_set,
    output logic              at_end
);
    localparam int SEL_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MAX_VL - 1);

    logic [MAX_VL-1:0] mask_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  vl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            idx_q  <= '0;
            vl_q   <= '0;
        end else if (load) begin
            mask_q <= mask_in;
            idx_q  <= '0;
            vl_q   <= vl_in;
        end else if (step) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    assign idx     = idx_q;
    assign at_end  = (idx_q >= vl_q);
    assign bit_set = (idx_q <= LAST_IDX) ? mask_q[idx_q[SEL_W-1:0]] : 1'b0;

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import twin_pred_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic src_zero_mode,
    input  logic dst_zero_mode,
    input  logic src_bit,
    input  logic dst_bit,
    input  logic src_end,
    input  logic dst_end,
    output logic load,
    output logic src_step,
    output logic dst_step,
    output logic issue,
    output logic src_is_zero,
    output logic wr_zero,
    output logic done
);
    seq_state_t state_q, state_d;
    pred_mode_t src_mode_q, dst_mode_q;
    logic       src_skip, dst_skip;

    // state register and captured modes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            src_mode_q <= PM_SKIP;
            dst_mode_q <= PM_SKIP;
        end else begin
            state_q <= state_d;
            if (load) begin
                src_mode_q <= pred_mode_t'(src_zero_mode);
                dst_mode_q <= pred_mode_t'(dst_zero_mode);
            end
        end
    end

    assign src_skip = (src_mode_q == PM_SKIP) && !src_bit;
    assign dst_skip = (dst_mode_q == PM_SKIP) && !dst_bit;

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        load        = 1'b0;
        src_step    = 1'b0;
        dst_step    = 1'b0;
        issue       = 1'b0;
        src_is_zero = 1'b0;
        wr_zero     = 1'b0;
        done        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                if (src_end || dst_end) begin
                    done    = 1'b1;
                    state_d = ST_IDLE;
                end else if (src_skip || dst_skip) begin
                    src_step = src_skip;
                    dst_step = dst_skip;
                end else begin
                    issue       = 1'b1;
                    src_step    = 1'b1;
                    dst_step    = 1'b1;
                    src_is_zero = !src_bit;
                    wr_zero     = !dst_bit;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/twin_pred_seq.sv
module twin_pred_seq #(
    parameter int MAX_VL = 64,
    parameter int IDX_W  = $clog2(MAX_VL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  vec_len,
    input  logic [MAX_VL-1:0] src_mask,
    input  logic [MAX_VL-1:0] dst_mask,
    input  logic              src_zero_mode,
    input  logic              dst_zero_mode,
    output logic [IDX_W-1:0]  src_idx,
    output logic [IDX_W-1:0]  dst_idx,
    output logic              src_is_zero,
    output logic              dst_wr_en,
    output logic              dst_wr_zero,
    output logic              done
);
    localparam logic [IDX_W-1:0] VL_CAP = IDX_W'(MAX_VL);

    logic [IDX_W-1:0] vl_eff;
    logic load, src_step, dst_step;
    logic src_bit, dst_bit, src_end, dst_end;

    assign vl_eff = (vec_len > VL_CAP) ? VL_CAP : vec_len;

    pred_cursor #(.MAX_VL(MAX_VL), .IDX_W(IDX_W)) u_src (
        .clk(clk), .rst_n(rst_n), .load(load), .step(src_step),
        .mask_in(src_mask), .vl_in(vl_eff),
        .idx(src_idx), .bit_set(src_bit), .at_end(src_end)
    );

    pred_cursor #(.MAX_VL(MAX_VL), .IDX_W(IDX_W)) u_dst (
        .clk(clk), .rst_n(rst_n), .load(load), .step(dst_step),
        .mask_in(dst_mask), .vl_in(vl_eff),
        .idx(dst_idx), .bit_set(dst_bit), .at_end(dst_end)
    );

    seq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_zero_mode(src_zero_mode), .dst_zero_mode(dst_zero_mode),
        .src_bit(src_bit), .dst_bit(dst_bit),
        .src_end(src_end), .dst_end(dst_end),
        .load(load), .src_step(src_step), .dst_step(dst_step),
        .issue(dst_wr_en), .src_is_zero(src_is_zero),
        .wr_zero(dst_wr_zero), .done(done)
    );

endmodule

// File: rtl/twin_pred_seq_chk.sv
module twin_pred_seq_chk #(
    parameter int MAX_VL = 64,
    parameter int IDX_W  = $clog2(MAX_VL + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] src_idx,
    input logic [IDX_W-1:0] dst_idx,
    input logic             src_is_zero,
    input logic             dst_wr_en,
    input logic             dst_wr_zero,
    input logic             done
);
    localparam logic [IDX_W-1:0] VL_CAP = IDX_W'(MAX_VL);

    assert_src_zero_issued_R4: assert property (@(posedge clk) disable iff (!rst_n)
        src_is_zero |-> dst_wr_en);

    assert_wr_zero_issued_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dst_wr_zero |-> dst_wr_en);

    assert_pair_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dst_wr_en |=> (src_idx == IDX_W'($past(src_idx) + 1'b1)) &&
                      (dst_idx == IDX_W'($past(dst_idx) + 1'b1)));

    assert_done_no_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !dst_wr_en);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !dst_wr_en);

    assert_idx_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dst_wr_en |-> (src_idx < VL_CAP) && (dst_idx < VL_CAP));

endmodule

bind twin_pred_seq twin_pred_seq_chk #(.MAX_VL(MAX_VL), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_idx(src_idx), .dst_idx(dst_idx),
    .src_is_zero(src_is_zero), .dst_wr_en(dst_wr_en),
    .dst_wr_zero(dst_wr_zero), .done(done)
);

// File: tb/sim_twin_pred_seq.sv
`timescale 1ns/1ps
module sim_twin_pred_seq;
    localparam int MAX_VL = 64;
    localparam int IDX_W  = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [IDX_W-1:0]  vec_len = '0;
    logic [MAX_VL-1:0] src_mask = '0;
    logic [MAX_VL-1:0] dst_mask = '0;
    logic              src_zero_mode = 1'b0;
    logic              dst_zero_mode = 1'b0;
    logic [IDX_W-1:0]  src_idx, dst_idx;
    logic              src_is_zero, dst_wr_en, dst_wr_zero, done;

    int checks = 0;
    int failures = 0;
    logic [15:0] exp_q[$];
    int    exp_cycles = 0;
    int    cyc = 0;
    bit    busy = 1'b0;
    string tag = "";

    always #4 clk = ~clk;

    twin_pred_seq #(.MAX_VL(MAX_VL), .IDX_W(IDX_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .vec_len(vec_len),
        .src_mask(src_mask), .dst_mask(dst_mask),
        .src_zero_mode(src_zero_mode), .dst_zero_mode(dst_zero_mode),
        .src_idx(src_idx), .dst_idx(dst_idx), .src_is_zero(src_is_zero),
        .dst_wr_en(dst_wr_en), .dst_wr_zero(dst_wr_zero), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: pops expected pairs and checks done timing
    always @(negedge clk) begin
        if (busy) begin
            cyc++;
            if (dst_wr_en) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, tag, "unexpected pair",
                          {src_idx, dst_idx, src_is_zero, dst_wr_zero}, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check({src_idx, dst_idx, src_is_zero, dst_wr_zero} == e, tag,
                          "pair {si,di,sz,wz}",
                          {src_idx, dst_idx, src_is_zero, dst_wr_zero}, e);
                end
            end
            if (done) begin
                check(cyc == exp_cycles, "R8", {tag, " done cycle"}, cyc, exp_cycles);
                check(exp_q.size() == 0, tag, "pairs left at done", exp_q.size(), 0);
                busy = 1'b0;
            end
        end
    end

    // driver: models the operation from the requirements, then launches it
    task automatic run_op(input string req, input int vl, input logic [63:0] sm,
                          input logic [63:0] dm, input bit sz, input bit dz);
        int si = 0;
        int di = 0;
        int n = 0;
        int vle;
        vle = (vl > MAX_VL) ? MAX_VL : vl;
        exp_q.delete();
        forever begin
            bit sb, db, ss, ds;
            n++;
            if (si >= vle || di >= vle) break;
            sb = sm[si];
            db = dm[di];
            ss = !sz && !sb;
            ds = !dz && !db;
            if (ss || ds) begin
                si += int'(ss);
                di += int'(ds);
            end else begin
                exp_q.push_back({7'(si), 7'(di), !sb, !db});
                si++;
                di++;
            end
        end
        exp_cycles = n;
        tag = req;
        @(negedge clk);
        vec_len = 7'(vl); src_mask = sm; dst_mask = dm;
        src_zero_mode = sz; dst_zero_mode = dz;
        start = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
        cyc = 0;
        busy = 1'b1;
        if (exp_cycles > 3) begin
            // R2: a second start with other inputs while running is ignored
            @(negedge clk);
            vec_len = '0; src_mask = '0; dst_mask = ~64'd0;
            src_zero_mode = ~sz; dst_zero_mode = ~dz;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
        check(!dst_wr_en && !done, "R1", {req, " idle after done"},
              {dst_wr_en, done}, 0);
    endtask

    initial begin
        #(200000 * 8);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!dst_wr_en && !done && !src_is_zero && !dst_wr_zero, "R1",
              "outputs in reset", {dst_wr_en, done, src_is_zero, dst_wr_zero}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!dst_wr_en && !done, "R1", "idle after reset", {dst_wr_en, done}, 0);

        run_op("R9",  0,   64'hFFFF, 64'hFFFF, 1'b1, 1'b1);
        run_op("R11", 12,  64'hF0F, 64'hF0F, 1'b0, 1'b0);
        run_op("R3",  4,   64'hA, 64'hF, 1'b0, 1'b0);
        run_op("R5",  4,   64'hF, 64'h6, 1'b0, 1'b0);
        run_op("R11", 8,   64'h96, 64'h5A, 1'b0, 1'b0);
        run_op("R4",  4,   64'h5, 64'h3, 1'b1, 1'b1);
        run_op("R6",  6,   64'h3F, 64'h29, 1'b0, 1'b1);
        run_op("R11", 4,   64'hA, 64'hA, 1'b1, 1'b0);
        run_op("R7",  16,  64'h0F0F, 64'h3333, 1'b0, 1'b0);
        run_op("R10", 64,  64'hDEAD_BEEF_0123_4567, 64'hFFFF_0000_FFFF_0000, 1'b0, 1'b1);
        run_op("R10", 100, 64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
        run_op("R10", 64,  64'h8000_0000_0000_0000, 64'h0, 1'b0, 1'b1);
        run_op("R2",  10,  64'h3FF, 64'h3FF, 1'b1, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule